// File: doc/BRIEF.md
# Dual-Mode Burst Address Sequencer

This block produces the address for each beat of a four-beat burst on a synchronous memory port. A new burst starts when either of two active-low strobes is low at a clock edge. One strobe comes from the processor and the other from a controller. The block then captures the full start address and clears its beat count. On later edges, with both strobes high, a low advance input moves the burst on by one beat.

Only the two least significant bits follow the burst pattern. The upper bits keep the value that was loaded for the whole burst. An order-select input chooses how the two low bits are formed:

- **Interleaved order** (order-select high): the start bits XOR the beat count.
- **Linear order** (order-select low): the start bits plus the beat count, modulo four.

Once four beats have been used, further steps wrap around the same group of four addresses. The byte-lane selects of a write beat can qualify a step, but they never cause one by themselves. The output is registered, so every change appears one clock after the edge that caused it.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `burst_addr` becomes all zeros on that edge, and the beat count is cleared.
- R2: When `proc_strobe_n` is low at an edge, `burst_addr` equals the `start_addr` sampled at that edge, one clock later. On that edge `adv_n` and `byte_sel_n` have no effect.
- R3: When `ctrl_strobe_n` is low at an edge and `proc_strobe_n` is high, `burst_addr` equals the sampled `start_addr` one clock later.
- R4: When both strobes are high and `adv_n` is low at an edge, the beat count increases by one, modulo 4.
- R5: When both strobes are high, `adv_n` is high and `order_sel` has not changed, `burst_addr` holds its value.
- R6: A low bit in `byte_sel_n` while `adv_n` is high and both strobes are high does not move the burst. `burst_addr` holds its value.
- R7: With `order_sel` = 1 (interleaved), `burst_addr[1:0]` = start[1:0] XOR count. For example, a start of 01 gives the sequence 01, 00, 11, 10.
- R8: With `order_sel` = 0 (linear), `burst_addr[1:0]` = (start[1:0] + count) mod 4. For example, a start of 10 gives the sequence 10, 11, 00, 01.
- R9: `burst_addr[ADDR_W-1:2]` keeps the loaded upper bits on every edge that does not load.
- R10: The fourth step after a load brings the count back to zero, so `burst_addr` returns to the start address.
- R11: `order_sel` is sampled on each edge. A change in the middle of a burst re-maps the current start and count in the next cycle, without reloading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_addr | input | ADDR_W | Address captured when a burst begins |
| proc_strobe_n | input | 1 | Processor burst-start strobe, active low |
| ctrl_strobe_n | input | 1 | Controller burst-start strobe, active low |
| adv_n | input | 1 | Advance request, active low |
| byte_sel_n | input | LANES | Write byte-lane selects, active low |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order |
| burst_addr | output | ADDR_W | Registered current burst address |

## Verification
Three pairs of events can land on the same clock edge:

- **A start strobe and a low advance.** The bench holds `adv_n` and the byte selects low on the load edge, then checks that the next address is the raw start address and not the start address plus one.
- **A step and the wrap.** Runs of five or more advances check that the count rolls over to zero on the fourth step and then continues from the start again.
- **A step and an order change.** `order_sel` is toggled on the same edge as an advance.

A behavioural model in the bench sees the same inputs and judges each of these edges by comparing its expected address with the design's output on every cycle.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_step_qual.sv
module burst_step_qual #(
  parameter int LANES = 2
) (
  input  logic             proc_strobe_n,
  input  logic             ctrl_strobe_n,
  input  logic             adv_n,
  input  logic [LANES-1:0] byte_sel_n,
  output logic             load,
  output logic             step
);
  logic strobes_idle;
  logic read_step;
  logic write_step;

  always_comb begin
    // Either strobe starts a burst; load outranks any advance request.
    load         = !proc_strobe_n || !ctrl_strobe_n;
    strobes_idle = proc_strobe_n && ctrl_strobe_n;
    read_step    = strobes_idle && !adv_n;
    // A write beat steps when a lane select and advance are both low.
    write_step   = strobes_idle && !adv_n && (|(~byte_sel_n));
    step         = read_step || write_step;
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 19,
  localparam int HI_W  = ADDR_W - BEAT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] load_addr,
  output beat_t             start_nxt,
  output beat_t             cnt_nxt,
  output logic [HI_W-1:0]   hi_nxt,
  output beat_t             cnt_q
);
  beat_t           start_q;
  logic [HI_W-1:0] hi_q;

  always_comb begin
    start_nxt = start_q;
    cnt_nxt   = cnt_q;
    hi_nxt    = hi_q;
    if (rst) begin
      start_nxt = '0;
      cnt_nxt   = '0;
      hi_nxt    = '0;
    end else if (load) begin
      start_nxt = load_addr[BEAT_W-1:0];
      cnt_nxt   = '0;
      hi_nxt    = load_addr[ADDR_W-1:BEAT_W];
    end else if (step) begin
      cnt_nxt   = cnt_q + beat_t'(1);
    end
  end

  always_ff @(posedge clk) begin
    start_q <= start_nxt;
    cnt_q   <= cnt_nxt;
    hi_q    <= hi_nxt;
  end

  assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (cnt_q == beat_t'($past(cnt_q) + 2'd1)));

  assert_count_clear_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == '0));

  assert_count_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    (step && !load && cnt_q == 2'd3) |=> (cnt_q == 2'd0));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
(
  input  beat_t  start_lo,
  input  beat_t  count,
  input  order_e order,
  output beat_t  addr_lo
);
  beat_t xor_form;
  beat_t add_form;

  always_comb begin
    xor_form = start_lo ^ count;
    add_form = start_lo + count;
    addr_lo  = (order == ORD_INTERLEAVE) ? xor_form : add_form;
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              proc_strobe_n,
  input  logic              ctrl_strobe_n,
  input  logic              adv_n,
  input  logic [LANES-1:0]  byte_sel_n,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] burst_addr
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic            load;
  logic            step;
  beat_t           start_nxt;
  beat_t           cnt_nxt;
  beat_t           cnt_q;
  beat_t           lo_nxt;
  logic [HI_W-1:0] hi_nxt;
  order_e          order;

  assign order = order_e'(order_sel);

  burst_step_qual #(.LANES(LANES)) u_qual (
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .adv_n         (adv_n),
    .byte_sel_n    (byte_sel_n),
    .load          (load),
    .step          (step)
  );

  burst_beat_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .step      (step),
    .load_addr (start_addr),
    .start_nxt (start_nxt),
    .cnt_nxt   (cnt_nxt),
    .hi_nxt    (hi_nxt),
    .cnt_q     (cnt_q)
  );

  burst_order_map u_map (
    .start_lo (start_nxt),
    .count    (cnt_nxt),
    .order    (order),
    .addr_lo  (lo_nxt)
  );

  always_ff @(posedge clk) begin
    burst_addr <= {hi_nxt, lo_nxt};
  end

  assert_proc_load_R2: assert property (@(posedge clk) disable iff (rst)
    !proc_strobe_n |=> (burst_addr == $past(start_addr)));

  assert_ctrl_load_R3: assert property (@(posedge clk) disable iff (rst)
    (proc_strobe_n && !ctrl_strobe_n) |=> (burst_addr == $past(start_addr)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (proc_strobe_n && ctrl_strobe_n && adv_n && order_sel == $past(order_sel))
    |=> $stable(burst_addr));

  assert_lane_no_step_R6: assert property (@(posedge clk) disable iff (rst)
    (proc_strobe_n && ctrl_strobe_n && adv_n && (|(~byte_sel_n)))
    |=> $stable(cnt_q));

  assert_upper_fixed_R9: assert property (@(posedge clk) disable iff (rst)
    (proc_strobe_n && ctrl_strobe_n)
    |=> (burst_addr[ADDR_W-1:BEAT_W] == $past(burst_addr[ADDR_W-1:BEAT_W])));
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int ADDR_W = 19;
  localparam int LANES  = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] start_addr = '0;
  logic              proc_strobe_n = 1'b1;
  logic              ctrl_strobe_n = 1'b1;
  logic              adv_n = 1'b1;
  logic [LANES-1:0]  byte_sel_n = '1;
  logic              order_sel = 1'b1;
  logic [ADDR_W-1:0] burst_addr;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // Behavioural reference state
  int    m_start = 0;
  int    m_cnt   = 0;
  int    m_hi    = 0;
  int    m_exp   = 0;
  int    m_low   = 0;
  bit    m_mode  = 1;
  bit    m_prev_mode = 1;
  string ev_tag  = "R1";
  bit    armed   = 0;

  always #2 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dut (
    .clk           (clk),
    .rst           (rst),
    .start_addr    (start_addr),
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .adv_n         (adv_n),
    .byte_sel_n    (byte_sel_n),
    .order_sel     (order_sel),
    .burst_addr    (burst_addr)
  );

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    armed <= 1'b1;
    m_prev_mode = m_mode;
    m_mode = order_sel;
    if (rst) begin
      m_start = 0; m_cnt = 0; m_hi = 0; ev_tag = "R1";
    end else if (!proc_strobe_n) begin
      m_start = start_addr & 3; m_hi = start_addr >> 2; m_cnt = 0; ev_tag = "R2";
    end else if (!ctrl_strobe_n) begin
      m_start = start_addr & 3; m_hi = start_addr >> 2; m_cnt = 0; ev_tag = "R3";
    end else if (!adv_n) begin
      m_cnt = (m_cnt + 1) % 4;
      ev_tag = (m_cnt == 0) ? "R10" : "R4";
    end else if (byte_sel_n != '1) begin
      ev_tag = "R6";
    end else begin
      ev_tag = (m_mode != m_prev_mode) ? "R11" : "R5";
    end
    m_low = m_mode ? (m_start ^ m_cnt) : ((m_start + m_cnt) % 4);
    m_exp = (m_hi << 2) | m_low;
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      check(ev_tag, int'(burst_addr), m_exp);
      check(m_mode ? "R7" : "R8", int'(burst_addr[1:0]), m_low);
      if (!rst) check("R9", int'(burst_addr >> 2), m_hi);
    end
  end

  task automatic drive(input bit p, input bit c, input bit a,
                       input logic [LANES-1:0] b, input bit m,
                       input logic [ADDR_W-1:0] addr);
    @(negedge clk);
    proc_strobe_n = p; ctrl_strobe_n = c; adv_n = a;
    byte_sel_n = b; order_sel = m; start_addr = addr;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset value observed above; release reset
    drive(1, 1, 1, '1, 1, '0);
    rst = 1'b0;
    // R2: processor load with advance and lane selects low: advance ignored
    drive(0, 1, 0, '0, 1, 19'h12341);
    for (int i = 0; i < 6; i++) drive(1, 1, 0, '1, 1, '0); // R7, R10 wrap
    // R8: linear start 10
    drive(0, 1, 1, '1, 0, 19'h00AB6);
    for (int i = 0; i < 5; i++) drive(1, 1, 0, '1, 0, '0);
    // R3: controller load, then holds and lane-only beats (R5, R6)
    drive(1, 0, 0, '1, 1, 19'h7FFF3);
    drive(1, 1, 1, '1, 1, '0);
    drive(1, 1, 1, 2'b01, 1, '0);
    drive(1, 1, 1, 2'b00, 1, '0);
    drive(1, 1, 0, 2'b10, 1, '0); // write step
    // R11: order change mid-burst, with and without a step
    drive(1, 1, 1, '1, 0, '0);
    drive(1, 1, 0, '1, 1, '0);
    drive(1, 1, 0, '1, 0, '0);
    // both strobes low at once
    drive(0, 0, 0, '0, 1, 19'h00005);
    for (int i = 0; i < 3000; i++) begin
      logic [ADDR_W-1:0] ra;
      ra = ADDR_W'($urandom);
      drive(($urandom % 6) != 0, ($urandom % 6) != 0, $urandom % 2,
            LANES'($urandom), ($urandom % 8) != 0, ra);
    end
    drive(1, 1, 1, '1, 1, '0);
    rst = 1'b1;
    drive(1, 1, 1, '1, 1, '0);
    @(negedge clk);
    @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      fails++;
      vectors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule